// File: doc/BRIEF.md
# Floating-Point Move-Multiple Transfer Sequencer

This block serves the coprocessor side of a main-processor/coprocessor dialog for a decoded move-multiple command on the floating-point registers. The command carries a direction bit, a two-bit mode and an 8-bit register mask. The block replies with an ordered series of response primitives. Each primitive has a come-again (CA) flag. The main processor acknowledges each primitive before the next one is shown.

In a dynamic-list command, the mask comes from a main-processor data register, which is fetched through a single-register primitive. In a static-list command, the mask comes with the command. Once the transfer-multiple primitive is acknowledged, every selected 12-byte register moves as three 32-bit beats, in ascending or descending register order. Beats leave on a source stream in register-to-memory commands and arrive on a sink stream in memory-to-register commands. A simple internal register array holds the register contents. A null primitive closes the dialog.

Top module: `fpmm_seq`

## Requirements
- R1: After a synchronous active-high reset, `cmd_ready` is 1 and `prim_valid`, `out_valid`, `in_ready` and `xfer_done` are 0.
- R2: When `cmd_mode[0]`=0 (static list), exactly two primitives follow. The first is transfer-multiple (`prim_code`=2) with CA=1. The second is null (`prim_code`=0) with CA=0.
- R3: When `cmd_mode[0]`=1 (dynamic list), exactly three primitives follow. The first is single main-register transfer (`prim_code`=1) with CA=1. The second is transfer-multiple (code 2) with CA=1. The third is null (code 0) with CA=0.
- R4: For a dynamic list, the mask is `mpu_word[7:0]`, captured on the cycle the single-register primitive is acknowledged. For a static list, the mask is `cmd_mask`. During transfer-multiple, `sel_mask` shows the active mask and `sel_count` shows its number of set bits.
- R5: When `cmd_mode[1]`=1, mask bit 7-i selects register i, and registers move in ascending order.
- R6: When `cmd_mode[1]`=0, mask bit i selects register i, and registers move from highest to lowest. This holds in both directions, including the invalid memory-to-register modes 00 and 01.
- R7: Each selected register moves as three 32-bit beats, with word 0 first. When `cmd_dir`=1, words leave on `out_*` from the array. When `cmd_dir`=0, words are taken from `in_*` into the array. A beat completes on valid and ready high together.
- R8: `xfer_done` is high for exactly the one cycle after the handshake of the last beat. The null primitive follows.
- R9: An all-zero mask still issues transfer-multiple. The null primitive follows immediately, with no beat and no `xfer_done`.
- R10: A command is taken only while `cmd_ready` is 1 (idle). `cmd_valid` at other times has no effect on the mask, the order or the primitives.
- R11: A shown primitive, and a shown `out_data` beat, are held stable until they are acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Idle, a command is taken |
| cmd_dir | input | 1 | 1 register-to-memory, 0 memory-to-register |
| cmd_mode | input | 2 | Bit 1: ascending order; bit 0: dynamic list |
| cmd_mask | input | 8 | Static register mask |
| prim_valid | output | 1 | Primitive shown |
| prim_code | output | 2 | 0 null, 1 single main-register transfer, 2 transfer-multiple |
| prim_ca | output | 1 | Come-again flag |
| prim_ack | input | 1 | Primitive acknowledged |
| mpu_word | input | 32 | Data register word returned with the acknowledge |
| sel_mask | output | 8 | Active register mask readback |
| sel_count | output | 4 | Number of registers to move |
| out_valid | output | 1 | Outgoing beat valid |
| out_data | output | 32 | Outgoing beat |
| out_ready | input | 1 | Outgoing beat taken |
| in_valid | input | 1 | Incoming beat valid |
| in_data | input | 32 | Incoming beat |
| in_ready | output | 1 | Incoming beat accepted |
| xfer_done | output | 1 | Last beat completed |

## Verification
The hardest situation to reach is a memory-to-register write in descending order through an invalid mode. No port shows where a beat landed in the array. The stimulus writes with modes 00 and 01 and then reads the whole array back in ascending order, so a misplaced word shows up as wrong data. A command offered during a transfer, random stalls on both streams, and all-zero static and dynamic masks make up the other directed corners.

// File: rtl/fpmm_pkg.sv
package fpmm_pkg;
  typedef enum logic [1:0] {
    PRIM_NULL     = 2'd0,
    PRIM_MPU_REG  = 2'd1,
    PRIM_CP_MULTI = 2'd2
  } prim_e;
endpackage

// File: rtl/fpmm_regfile.sv
module fpmm_regfile #(
  parameter int DEPTH = 24,
  parameter int DW    = 32
) (
  input  logic                     clk,
  input  logic                     we,
  input  logic [$clog2(DEPTH)-1:0] waddr,
  input  logic [DW-1:0]            wdata,
  input  logic [$clog2(DEPTH)-1:0] raddr,
  output logic [DW-1:0]            rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/fpmm_pick.sv
module fpmm_pick #(
  parameter int NREG = 8
) (
  input  logic [NREG-1:0]         pend,
  input  logic                    predec,
  output logic                    any,
  output logic [$clog2(NREG)-1:0] bit_idx,
  output logic [$clog2(NREG)-1:0] reg_idx
);
  localparam int IW = $clog2(NREG);

  // Highest pending bit wins: later iterations overwrite earlier ones.
  always_comb begin
    bit_idx = '0;
    reg_idx = '0;
    for (int k = 0; k < NREG; k++) begin
      if (pend[k]) begin
        bit_idx = IW'(k);
        reg_idx = predec ? IW'(k) : IW'(NREG - 1 - k);
      end
    end
  end

  assign any = |pend;
endmodule

// File: rtl/fpmm_beat.sv
module fpmm_beat #(
  parameter int NREG  = 8,
  parameter int BEATS = 3,
  parameter int DW    = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic            dir,
  input  logic            predec,
  input  logic [NREG-1:0] mask,
  output logic            out_valid,
  output logic [DW-1:0]   out_data,
  input  logic            out_ready,
  input  logic            in_valid,
  input  logic [DW-1:0]   in_data,
  output logic            in_ready,
  output logic            done
);
  localparam int IW    = $clog2(NREG);
  localparam int BW    = (BEATS > 1) ? $clog2(BEATS) : 1;
  localparam int DEPTH = NREG * BEATS;
  localparam int AW    = $clog2(DEPTH);

  typedef enum logic [2:0] {E_IDLE, E_SEEK, E_READ, E_SEND, E_RECV} est_e;

  est_e            st;
  logic [NREG-1:0] pend;
  logic            dir_q, predec_q;
  logic [IW-1:0]   cur_reg;
  logic [BW-1:0]   beat;
  logic            pick_any;
  logic [IW-1:0]   pick_bit, pick_reg;
  logic [AW-1:0]   addr;
  logic            wr_en, last_beat, hs;

  fpmm_pick #(.NREG(NREG)) u_pick (
    .pend    (pend),
    .predec  (predec_q),
    .any     (pick_any),
    .bit_idx (pick_bit),
    .reg_idx (pick_reg)
  );

  assign addr      = AW'(cur_reg) * AW'(BEATS) + AW'(beat);
  assign wr_en     = (st == E_RECV) && in_valid;
  assign in_ready  = (st == E_RECV);
  assign last_beat = (beat == BW'(BEATS - 1));
  assign hs        = ((st == E_SEND) && out_ready) || wr_en;

  fpmm_regfile #(.DEPTH(DEPTH), .DW(DW)) u_rf (
    .clk   (clk),
    .we    (wr_en),
    .waddr (addr),
    .wdata (in_data),
    .raddr (addr),
    .rdata (out_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= E_IDLE;
      pend      <= '0;
      dir_q     <= 1'b0;
      predec_q  <= 1'b0;
      cur_reg   <= '0;
      beat      <= '0;
      out_valid <= 1'b0;
      done      <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        E_IDLE: begin
          if (start) begin
            pend     <= mask;
            dir_q    <= dir;
            predec_q <= predec;
            st       <= E_SEEK;
          end
        end
        E_SEEK: begin
          if (pick_any) begin
            cur_reg <= pick_reg;
            pend    <= pend & ~(NREG'(1) << pick_bit);
            beat    <= '0;
            st      <= dir_q ? E_READ : E_RECV;
          end else begin
            done <= 1'b1;
            st   <= E_IDLE;
          end
        end
        E_READ: begin
          out_valid <= 1'b1;
          st        <= E_SEND;
        end
        default: begin
          if (hs) begin
            out_valid <= 1'b0;
            if (last_beat) begin
              if (pend == '0) begin
                done <= 1'b1;
                st   <= E_IDLE;
              end else begin
                st <= E_SEEK;
              end
            end else begin
              beat <= beat + BW'(1);
              st   <= dir_q ? E_READ : E_RECV;
            end
          end
        end
      endcase
    end
  end

  AST_OUT_STABLE: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_data)); // R11
  AST_DIR_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(out_valid && in_ready)); // R7
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R8
  AST_BEAT_LIMIT: assert property (@(posedge clk) disable iff (rst)
    int'(beat) < BEATS); // R7
endmodule

// File: rtl/fpmm_seq.sv
module fpmm_seq #(
  parameter int NREG  = 8,
  parameter int BEATS = 3,
  parameter int DW    = 32
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       cmd_valid,
  output logic                       cmd_ready,
  input  logic                       cmd_dir,
  input  logic [1:0]                 cmd_mode,
  input  logic [NREG-1:0]            cmd_mask,
  output logic                       prim_valid,
  output logic [1:0]                 prim_code,
  output logic                       prim_ca,
  input  logic                       prim_ack,
  input  logic [DW-1:0]              mpu_word,
  output logic [NREG-1:0]            sel_mask,
  output logic [$clog2(NREG+1)-1:0]  sel_count,
  output logic                       out_valid,
  output logic [DW-1:0]              out_data,
  input  logic                       out_ready,
  input  logic                       in_valid,
  input  logic [DW-1:0]              in_data,
  output logic                       in_ready,
  output logic                       xfer_done
);
  import fpmm_pkg::*;

  localparam int CW = $clog2(NREG + 1);

  typedef enum logic [2:0] {S_IDLE, S_PSINGLE, S_PMULTI, S_XFER, S_PNULL} sst_e;

  sst_e            st;
  prim_e           prim_q;
  logic [NREG-1:0] mask_q;
  logic            dir_q, predec_q, start_q;
  logic            acked;
  logic [CW-1:0]   ones;

  assign cmd_ready = (st == S_IDLE);
  assign prim_code = prim_q;
  assign acked     = prim_valid && prim_ack;
  assign sel_mask  = mask_q;
  assign sel_count = ones;

  always_comb begin
    ones = '0;
    for (int i = 0; i < NREG; i++) ones = ones + CW'(mask_q[i]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= S_IDLE;
      prim_q     <= PRIM_NULL;
      prim_valid <= 1'b0;
      prim_ca    <= 1'b0;
      mask_q     <= '0;
      dir_q      <= 1'b0;
      predec_q   <= 1'b0;
      start_q    <= 1'b0;
    end else begin
      start_q <= 1'b0;
      case (st)
        S_IDLE: begin
          if (cmd_valid) begin
            dir_q      <= cmd_dir;
            predec_q   <= ~cmd_mode[1];
            prim_valid <= 1'b1;
            prim_ca    <= 1'b1;
            if (cmd_mode[0]) begin
              prim_q <= PRIM_MPU_REG;
              st     <= S_PSINGLE;
            end else begin
              mask_q <= cmd_mask;
              prim_q <= PRIM_CP_MULTI;
              st     <= S_PMULTI;
            end
          end
        end
        S_PSINGLE: begin
          if (acked) begin
            mask_q <= mpu_word[NREG-1:0];
            prim_q <= PRIM_CP_MULTI;
            st     <= S_PMULTI;
          end
        end
        S_PMULTI: begin
          if (acked) begin
            if (mask_q == '0) begin
              prim_q  <= PRIM_NULL;
              prim_ca <= 1'b0;
              st      <= S_PNULL;
            end else begin
              prim_valid <= 1'b0;
              start_q    <= 1'b1;
              st         <= S_XFER;
            end
          end
        end
        S_XFER: begin
          if (xfer_done) begin
            prim_valid <= 1'b1;
            prim_q     <= PRIM_NULL;
            prim_ca    <= 1'b0;
            st         <= S_PNULL;
          end
        end
        default: begin
          if (acked) begin
            prim_valid <= 1'b0;
            st         <= S_IDLE;
          end
        end
      endcase
    end
  end

  fpmm_beat #(.NREG(NREG), .BEATS(BEATS), .DW(DW)) u_beat (
    .clk       (clk),
    .rst       (rst),
    .start     (start_q),
    .dir       (dir_q),
    .predec    (predec_q),
    .mask      (mask_q),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_ready (out_ready),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .in_ready  (in_ready),
    .done      (xfer_done)
  );

  AST_PRIM_HOLD: assert property (@(posedge clk) disable iff (rst)
    prim_valid && !prim_ack |=> prim_valid && $stable(prim_code) && $stable(prim_ca)); // R11
  AST_NULL_NO_CA: assert property (@(posedge clk) disable iff (rst)
    prim_valid && prim_code == PRIM_NULL |-> !prim_ca); // R2
  AST_CA_SET: assert property (@(posedge clk) disable iff (rst)
    prim_valid && prim_code != PRIM_NULL |-> prim_ca); // R3
  AST_DONE_IN_XFER: assert property (@(posedge clk) disable iff (rst)
    xfer_done |-> st == S_XFER); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    cmd_ready |-> !prim_valid && !out_valid && !in_ready); // R10
  AST_MASK_HELD: assert property (@(posedge clk) disable iff (rst)
    st == S_XFER |=> $stable(sel_mask)); // R4
endmodule

// File: tb/fpmm_seq_tb.sv
module fpmm_seq_tb;
  localparam int NREG = 8, BEATS = 3, DW = 32;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst, cmd_valid, cmd_ready, cmd_dir;
  logic [1:0] cmd_mode;
  logic [7:0] cmd_mask, sel_mask;
  logic prim_valid, prim_ca, prim_ack;
  logic [1:0] prim_code;
  logic [31:0] mpu_word, out_data, in_data;
  logic [3:0] sel_count;
  logic out_valid, out_ready, in_valid, in_ready, xfer_done;

  fpmm_seq #(.NREG(NREG), .BEATS(BEATS), .DW(DW)) u_dut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_dir(cmd_dir), .cmd_mode(cmd_mode), .cmd_mask(cmd_mask),
    .prim_valid(prim_valid), .prim_code(prim_code), .prim_ca(prim_ca),
    .prim_ack(prim_ack), .mpu_word(mpu_word), .sel_mask(sel_mask),
    .sel_count(sel_count), .out_valid(out_valid), .out_data(out_data),
    .out_ready(out_ready), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .xfer_done(xfer_done)
  );

  int n_chk = 0, n_fail = 0;
  int mon_out = 0, mon_in = 0, mon_done = 0;
  logic [31:0] model [NREG*BEATS];
  bit model_ok [NREG*BEATS];

  always @(posedge clk) begin
    if (out_valid && out_ready) mon_out++;
    if (in_valid && in_ready) mon_in++;
    if (xfer_done) mon_done++;
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int ones8(input logic [7:0] m);
    int c = 0;
    for (int i = 0; i < 8; i++) c += int'(m[i]);
    return c;
  endfunction

  // Register selected at scan step s (mask bit 7-s): ascending uses s, descending uses 7-s.
  function automatic int reg_of(input int s, input bit predec);
    return predec ? 7 - s : s;
  endfunction

  task automatic wait_prim(input string tag);
    int t = 0;
    while (!prim_valid && t < 100) begin @(negedge clk); t++; end
    chk(prim_valid, tag, 0, 1);
  endtask

  task automatic ack_prim(input logic [31:0] w);
    mpu_word = w; prim_ack = 1'b1;
    @(negedge clk);
    prim_ack = 1'b0;
  endtask

  task automatic run_cmd(input bit dir, input logic [1:0] mode, input logic [7:0] smask,
                         input logic [31:0] word, input bit inject);
    bit dyn = mode[0];
    bit predec = ~mode[1];
    logic [7:0] m = dyn ? word[7:0] : smask;
    int o0, i0, d0, t;
    t = 0;
    while (!cmd_ready && t < 100) begin @(negedge clk); t++; end
    cmd_valid = 1'b1; cmd_dir = dir; cmd_mode = mode; cmd_mask = smask;
    @(negedge clk);
    cmd_valid = 1'b0;
    o0 = mon_out; i0 = mon_in; d0 = mon_done;
    if (inject) begin
      chk(!cmd_ready, "R10 busy", cmd_ready, 0);
      cmd_valid = 1'b1; cmd_mode = ~mode; cmd_mask = ~m; cmd_dir = ~dir;
      @(negedge clk);
      cmd_valid = 1'b0;
    end
    if (dyn) begin
      wait_prim("R3 single shown");
      chk(prim_code == 2'd1 && prim_ca, "R3 single code/ca", {prim_code, prim_ca}, 3'b011);
      ack_prim(word);
    end
    wait_prim(dyn ? "R3 multi shown" : "R2 multi shown");
    chk(prim_code == 2'd2 && prim_ca, dyn ? "R3 multi code/ca" : "R2 multi code/ca",
        {prim_code, prim_ca}, 3'b101);
    chk(sel_mask == m, inject ? "R10 mask kept" : "R4 sel_mask", sel_mask, m);
    chk(int'(sel_count) == ones8(m), "R4 sel_count", sel_count, ones8(m));
    ack_prim(32'hdead_0000);
    if (m != 8'h00) begin
      for (int s = 0; s < 8; s++) begin
        if (m[7-s]) begin
          int r = reg_of(s, predec);
          for (int b = 0; b < BEATS; b++) begin
            int a = r * BEATS + b;
            int stall = int'($urandom_range(0, 2));
            if (dir) begin
              t = 0;
              while (!out_valid && t < 100) begin @(negedge clk); t++; end
              repeat (stall) @(negedge clk);
              chk(out_valid, "R11 out held", out_valid, 1);
              if (model_ok[a])
                chk(out_data == model[a], predec ? "R6 out order/data" : "R5 out order/data",
                    out_data, model[a]);
              out_ready = 1'b1;
              @(negedge clk);
              out_ready = 1'b0;
            end else begin
              logic [31:0] d = $urandom;
              repeat (stall) @(negedge clk);
              in_valid = 1'b1; in_data = d;
              t = 0;
              while (!in_ready && t < 100) begin @(negedge clk); t++; end
              chk(in_ready, "R7 in accepted", in_ready, 1);
              @(negedge clk);
              in_valid = 1'b0;
              model[a] = d; model_ok[a] = 1'b1;
            end
          end
        end
      end
      chk(xfer_done, "R8 done after last beat", xfer_done, 1);
      @(negedge clk);
      chk(!xfer_done, "R8 done single cycle", xfer_done, 0);
    end
    wait_prim(dyn ? "R3 null shown" : "R2 null shown");
    chk(prim_code == 2'd0 && !prim_ca, dyn ? "R3 null code/ca" : "R2 null code/ca",
        {prim_code, prim_ca}, 3'b000);
    ack_prim(32'h0);
    chk(!prim_valid && cmd_ready, "R2 dialog ends", {prim_valid, cmd_ready}, 2'b01);
    chk((mon_out - o0) + (mon_in - i0) == BEATS * ones8(m),
        (m == 0) ? "R9 no beats" : "R7 beat count",
        (mon_out - o0) + (mon_in - i0), BEATS * ones8(m));
    chk((mon_done - d0) == ((m != 0) ? 1 : 0), (m == 0) ? "R9 no done" : "R8 one done",
        mon_done - d0, (m != 0) ? 1 : 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h00C0FFEE));
    for (int i = 0; i < NREG*BEATS; i++) model_ok[i] = 1'b0;
    rst = 1'b1; cmd_valid = 0; cmd_dir = 0; cmd_mode = 0; cmd_mask = 0;
    prim_ack = 0; mpu_word = 0; out_ready = 0; in_valid = 0; in_data = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(cmd_ready, "R1 cmd_ready", cmd_ready, 1);
    chk(!prim_valid, "R1 prim_valid", prim_valid, 0);
    chk(!out_valid && !in_ready && !xfer_done, "R1 streams idle",
        {out_valid, in_ready, xfer_done}, 0);

    // Fill all registers ascending, read back ascending then descending.
    run_cmd(1'b0, 2'b10, 8'hFF, 0, 1'b0);
    run_cmd(1'b1, 2'b10, 8'hFF, 0, 1'b0);   // R5
    run_cmd(1'b1, 2'b00, 8'hA5, 0, 1'b0);   // R6 static descending
    run_cmd(1'b1, 2'b01, 8'h00, 32'h1234_563C, 1'b0); // R3 R4 dynamic descending
    run_cmd(1'b1, 2'b11, 8'h00, 32'hFFFF_FF81, 1'b0); // R4 upper bits ignored
    // R6 invalid memory-to-register modes, verified by ascending full readback
    run_cmd(1'b0, 2'b00, 8'hC3, 0, 1'b0);
    run_cmd(1'b0, 2'b01, 8'h00, 32'h0000_005A, 1'b0);
    run_cmd(1'b1, 2'b10, 8'hFF, 0, 1'b0);
    // R9 zero masks
    run_cmd(1'b1, 2'b10, 8'h00, 0, 1'b0);
    run_cmd(1'b0, 2'b01, 8'hFF, 32'hFFFF_FF00, 1'b0);
    // R10 command offered while busy
    run_cmd(1'b1, 2'b10, 8'h81, 0, 1'b1);
    run_cmd(1'b0, 2'b11, 8'h00, 32'h0000_0042, 1'b1);
    // Random mix
    for (int k = 0; k < 30; k++) begin
      logic [1:0] md = 2'($urandom_range(0, 3));
      run_cmd(1'($urandom_range(0, 1)), md, 8'($urandom), $urandom, 1'b0);
    end
    run_cmd(1'b1, 2'b10, 8'hFF, 0, 1'b0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule